// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the sequencer for a processor core built around one shared internal bus. A small binary step counter, decoded into one-hot timing lines T1..T6, is combined with a decoded opcode and the zero and negative flags. The combination is plain AND-OR logic, and it produces every transfer strobe for one clock cycle: which register drives the bus, which registers latch it, the ALU function, whether the constant four is added, and the memory read and write requests.

Every instruction starts with the same three fetch steps. It then runs from one to three execute steps and raises `last_step`, which sends the counter back to T1 on the next edge. A memory request that is still waiting freezes the counter, and so does deasserting `seq_en`. All outputs depend only on the current step and on the instruction fields, so a frozen step keeps its strobes asserted. The opcode and register fields come from the instruction register held in the datapath.

Top module: `step_ctrl_unit`

## Requirements
- R1: An asynchronous low level on `rst_ni` places the counter at T1 at once, whatever step it held. T1 is therefore visible on the outputs throughout reset and on the first cycle after release.
- R2: For every opcode the first three steps are identical. T1: `pc_to_bus`, `mar_load`, `mem_rd`, `add_const4`, `z_load`. T2: `z_to_bus`, `pc_load`, `y_load`, `mem_wait`, `mdr_load_ext`. T3: `mdr_to_bus`, `ir_load`. `alu_op` is 0 (add) in every step that does not name another function.
- R3: While `mem_wait` is high and `mem_ack` is low, the counter keeps its step, and the same strobes repeat each cycle.
- R4: While `seq_en` is low, the counter keeps its step.
- R5: When `last_step` is high in a cycle that is not frozen, the next cycle is T1.
- R6: Opcodes 4..7 (add, subtract, and, or; `alu_op` 0..3) use three execute steps. T4: destination to bus, `y_load`. T5: source to bus, ALU function, `z_load`. T6: `z_to_bus`, destination load, `last_step`.
- R7: Opcode 2 loads from memory at the address held in the source register. T4: source to bus, `mar_load`, `mem_rd`. T5: `mdr_load_ext`, `mem_wait`. T6: `mdr_to_bus`, destination load, `last_step`.
- R8: Opcode 3 stores to memory. T4: destination (address) to bus, `mar_load`. T5: source (data) to bus, `mdr_load_int`. T6: `mem_wr`, `mem_wait`, `last_step`.
- R9: Opcode 0 (register copy: source to bus, destination load) and opcode 1 (immediate: `imm_to_bus`, destination load) each finish at T4 with `last_step`.
- R10: Opcode 8 (compare). T4: `imm_to_bus`, `y_load`. T5: destination to bus, `alu_op` 1, `last_step`.
- R11: Opcodes 9 (always), 10 (taken when the zero flag is 0), 11 (taken when the zero flag is 1) and 12 (taken when the negative flag is 1) branch. T4: `imm_to_bus`, `z_load`, `alu_op` 0. When the condition fails, `last_step` is also raised at T4. Otherwise T5: `z_to_bus`, `pc_load`, `last_step`.
- R12: Opcodes 13 (increment, `alu_op` 4), 14 (invert, `alu_op` 5) and 15 (shift left, `alu_op` 6). T4: destination to bus, ALU function, `z_load`. T5: `z_to_bus`, destination load, `last_step`.
- R13: `gpr_load` and `gpr_to_bus` are one-hot or zero, and the bit set is the one selected by the field. At most one source drives the bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Sequencing enable; low freezes the step |
| opcode | input | 4 | Opcode field of the instruction register |
| dst_idx | input | REG_W | Destination (first operand) register field |
| src_idx | input | REG_W | Source (second operand) register field |
| flag_zero | input | 1 | Zero condition flag |
| flag_neg | input | 1 | Negative condition flag |
| mem_ack | input | 1 | Memory transfer complete |
| pc_to_bus | output | 1 | Program counter drives the bus |
| pc_load | output | 1 | Program counter loads from the bus |
| mar_load | output | 1 | Address register loads from the bus |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wait | output | 1 | Step waits for `mem_ack` |
| mdr_load_ext | output | 1 | Data register loads from the memory data lines |
| mdr_load_int | output | 1 | Data register loads from the internal bus |
| mdr_to_bus | output | 1 | Data register drives the bus |
| ir_load | output | 1 | Instruction register loads |
| y_load | output | 1 | ALU operand latch loads |
| z_load | output | 1 | ALU result latch loads |
| z_to_bus | output | 1 | ALU result latch drives the bus |
| add_const4 | output | 1 | ALU first operand is the constant four instead of the operand latch |
| imm_to_bus | output | 1 | Offset field of the instruction drives the bus |
| last_step | output | 1 | Final step of the instruction |
| alu_op | output | 3 | ALU function code |
| gpr_load | output | 2**REG_W | Per-register load strobes |
| gpr_to_bus | output | 2**REG_W | Per-register bus drive strobes |

## Verification
The bench builds the block with `REG_W` = 3, which gives eight general registers. Field values 0 and 7 then reach the lowest and highest bits of both one-hot strobe vectors, and every full control word stays short enough to compare whole each cycle. With this width, each opcode is run with several register pairs, every branch with its condition both met and failed, multi-cycle memory stalls at all three waiting steps, sequencing freezes during fetch and during execute, and a reset applied in the middle of an instruction.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int OP_W      = 4;
  localparam int ALU_W     = 3;
  localparam int MAX_STEPS = 6;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  typedef enum logic [OP_W-1:0] {
    OP_MOV = 4'd0, OP_LDI, OP_LDM, OP_STM,
    OP_ADD, OP_SUB, OP_AND, OP_OR,
    OP_CMP, OP_BRA, OP_BNZ, OP_BZ, OP_BM,
    OP_INC, OP_NOT, OP_SHL
  } opcode_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0, ALU_SUB, ALU_AND, ALU_OR, ALU_INC, ALU_NOT, ALU_SHL
  } alu_e;

  typedef enum logic [1:0] {CND_NONE, CND_ZERO, CND_NONZERO, CND_NEG} cond_e;

  typedef struct packed {
    logic  mov, ldi, ldm, stm, alu2, cmp, br, unary;
    cond_e cond;
    alu_e  alu;
  } ins_class_t;

  typedef struct packed {
    logic pc_to_bus, pc_load, mar_load, mem_rd, mem_wr, mem_wait;
    logic mdr_load_ext, mdr_load_int, mdr_to_bus, ir_load;
    logic y_load, z_load, z_to_bus, add_const4, imm_to_bus, last_step;
    alu_e alu;
    logic gpr_ld_en, gpr_drv_en;
  } ctrl_sig_t;
endpackage

// File: rtl/ctrl_step_counter.sv
module ctrl_step_counter
  import ctrl_pkg::*;
#(
  parameter int STEPS = MAX_STEPS,
  parameter int SW    = STEP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          restart,
  output logic [SW-1:0] step_q,
  output logic [STEPS:1] t_hot
);
  logic [SW-1:0] step_d;

  // next-state: count up, or return to T1 on the final step
  always_comb begin
    step_d = step_q + SW'(1);
    if (restart || (step_q == SW'(STEPS))) step_d = SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= SW'(1);
    else if (advance) step_q <= step_d;
  end

  // step decoder: one timing line per step
  generate
    for (genvar k = 1; k <= STEPS; k++) begin : g_tdec
      assign t_hot[k] = (step_q == SW'(k));
    end
  endgenerate

  assert_step_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q >= SW'(1)) && (step_q <= SW'(STEPS)));
endmodule

// File: rtl/ctrl_instr_decode.sv
module ctrl_instr_decode
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ins_class_t      cls
);
  always_comb begin
    cls      = '0;
    cls.cond = CND_NONE;
    cls.alu  = ALU_ADD;
    case (opcode_e'(op))
      OP_MOV: cls.mov = 1'b1;
      OP_LDI: cls.ldi = 1'b1;
      OP_LDM: cls.ldm = 1'b1;
      OP_STM: cls.stm = 1'b1;
      OP_ADD: begin cls.alu2 = 1'b1; cls.alu = ALU_ADD; end
      OP_SUB: begin cls.alu2 = 1'b1; cls.alu = ALU_SUB; end
      OP_AND: begin cls.alu2 = 1'b1; cls.alu = ALU_AND; end
      OP_OR:  begin cls.alu2 = 1'b1; cls.alu = ALU_OR;  end
      OP_CMP: begin cls.cmp  = 1'b1; cls.alu = ALU_SUB; end
      OP_BRA: cls.br = 1'b1;
      OP_BNZ: begin cls.br = 1'b1; cls.cond = CND_NONZERO; end
      OP_BZ:  begin cls.br = 1'b1; cls.cond = CND_ZERO;    end
      OP_BM:  begin cls.br = 1'b1; cls.cond = CND_NEG;     end
      OP_INC: begin cls.unary = 1'b1; cls.alu = ALU_INC; end
      OP_NOT: begin cls.unary = 1'b1; cls.alu = ALU_NOT; end
      OP_SHL: begin cls.unary = 1'b1; cls.alu = ALU_SHL; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctrl_signal_encode.sv
module ctrl_signal_encode
  import ctrl_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [MAX_STEPS:1] t,
  input  ins_class_t         cls,
  input  logic [REG_W-1:0]   dst_idx,
  input  logic [REG_W-1:0]   src_idx,
  input  logic               flag_zero,
  input  logic               flag_neg,
  output ctrl_sig_t          sig,
  output logic [REG_W-1:0]   ld_idx,
  output logic [REG_W-1:0]   drv_idx
);
  logic br_skip;

  always_comb begin
    case (cls.cond)
      CND_ZERO:    br_skip = ~flag_zero;
      CND_NONZERO: br_skip = flag_zero;
      CND_NEG:     br_skip = ~flag_neg;
      default:     br_skip = 1'b0;
    endcase
  end

  // sum-of-products of timing lines and instruction classes
  always_comb begin
    sig              = '0;
    sig.pc_to_bus    = t[1];
    sig.add_const4   = t[1];
    sig.mar_load     = t[1] | (t[4] & (cls.ldm | cls.stm));
    sig.mem_rd       = t[1] | (t[4] & cls.ldm);
    sig.z_load       = t[1] | (t[5] & cls.alu2) | (t[4] & (cls.br | cls.unary));
    sig.z_to_bus     = t[2] | (t[6] & cls.alu2) | (t[5] & (cls.br | cls.unary));
    sig.pc_load      = t[2] | (t[5] & cls.br);
    sig.y_load       = t[2] | (t[4] & (cls.alu2 | cls.cmp));
    sig.mem_wait     = t[2] | (t[5] & cls.ldm) | (t[6] & cls.stm);
    sig.mdr_load_ext = t[2] | (t[5] & cls.ldm);
    sig.mdr_load_int = t[5] & cls.stm;
    sig.mdr_to_bus   = t[3] | (t[6] & cls.ldm);
    sig.ir_load      = t[3];
    sig.imm_to_bus   = t[4] & (cls.ldi | cls.cmp | cls.br);
    sig.mem_wr       = t[6] & cls.stm;
    sig.last_step    = (t[4] & (cls.mov | cls.ldi | (cls.br & br_skip)))
                     | (t[5] & (cls.cmp | cls.br | cls.unary))
                     | (t[6] & (cls.alu2 | cls.ldm | cls.stm));
    sig.alu          = ALU_ADD;
    if ((t[5] & (cls.alu2 | cls.cmp)) | (t[4] & cls.unary)) sig.alu = cls.alu;
    sig.gpr_drv_en   = (t[4] & (cls.mov | cls.ldm | cls.stm | cls.alu2 | cls.unary))
                     | (t[5] & (cls.stm | cls.alu2 | cls.cmp));
    sig.gpr_ld_en    = (t[4] & (cls.mov | cls.ldi)) | (t[5] & cls.unary)
                     | (t[6] & (cls.alu2 | cls.ldm));
    drv_idx = ((t[4] & (cls.mov | cls.ldm)) | (t[5] & (cls.stm | cls.alu2)))
            ? src_idx : dst_idx;
    ld_idx  = dst_idx;
  end
endmodule

// File: rtl/step_ctrl_unit.sv
module step_ctrl_unit
  import ctrl_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int NREG = 1 << REG_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              seq_en,
  input  logic [OP_W-1:0]   opcode,
  input  logic [REG_W-1:0]  dst_idx,
  input  logic [REG_W-1:0]  src_idx,
  input  logic              flag_zero,
  input  logic              flag_neg,
  input  logic              mem_ack,
  output logic              pc_to_bus,
  output logic              pc_load,
  output logic              mar_load,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_wait,
  output logic              mdr_load_ext,
  output logic              mdr_load_int,
  output logic              mdr_to_bus,
  output logic              ir_load,
  output logic              y_load,
  output logic              z_load,
  output logic              z_to_bus,
  output logic              add_const4,
  output logic              imm_to_bus,
  output logic              last_step,
  output logic [ALU_W-1:0]  alu_op,
  output logic [NREG-1:0]   gpr_load,
  output logic [NREG-1:0]   gpr_to_bus
);
  logic [1:0]           rst_pipe;
  logic                 rst_n_int;
  logic [STEP_W-1:0]    step_q;
  logic [MAX_STEPS:1]   t_hot;
  ins_class_t           cls;
  ctrl_sig_t            sig;
  logic [REG_W-1:0]     ld_idx, drv_idx;
  logic                 stall, advance;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  assign stall   = sig.mem_wait & ~mem_ack;
  assign advance = seq_en & ~stall;

  ctrl_step_counter #(.STEPS(MAX_STEPS), .SW(STEP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .advance(advance), .restart(sig.last_step),
    .step_q(step_q), .t_hot(t_hot)
  );

  ctrl_instr_decode u_dec (.op(opcode), .cls(cls));

  ctrl_signal_encode #(.REG_W(REG_W)) u_enc (
    .t(t_hot), .cls(cls), .dst_idx(dst_idx), .src_idx(src_idx),
    .flag_zero(flag_zero), .flag_neg(flag_neg),
    .sig(sig), .ld_idx(ld_idx), .drv_idx(drv_idx)
  );

  assign pc_to_bus    = sig.pc_to_bus;
  assign pc_load      = sig.pc_load;
  assign mar_load     = sig.mar_load;
  assign mem_rd       = sig.mem_rd;
  assign mem_wr       = sig.mem_wr;
  assign mem_wait     = sig.mem_wait;
  assign mdr_load_ext = sig.mdr_load_ext;
  assign mdr_load_int = sig.mdr_load_int;
  assign mdr_to_bus   = sig.mdr_to_bus;
  assign ir_load      = sig.ir_load;
  assign y_load       = sig.y_load;
  assign z_load       = sig.z_load;
  assign z_to_bus     = sig.z_to_bus;
  assign add_const4   = sig.add_const4;
  assign imm_to_bus   = sig.imm_to_bus;
  assign last_step    = sig.last_step;
  assign alu_op       = sig.alu;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_gpr
      assign gpr_load[g]   = sig.gpr_ld_en  & (ld_idx  == REG_W'(g));
      assign gpr_to_bus[g] = sig.gpr_drv_en & (drv_idx == REG_W'(g));
    end
  endgenerate

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mem_wait && !mem_ack) |=> $stable(step_q));
  assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    !seq_en |=> $stable(step_q));
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (seq_en && !(mem_wait && !mem_ack) && last_step) |=> (step_q == STEP_W'(1)));
  assert_gpr_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(gpr_load) && $onehot0(gpr_to_bus));
  assert_bus_single_R13: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones({|gpr_to_bus, pc_to_bus, mdr_to_bus, z_to_bus, imm_to_bus}) <= 1);
endmodule

// File: tb/sim_step_ctrl_unit.sv
module sim_step_ctrl_unit;
  localparam int REG_W = 3;
  localparam int NREG  = 1 << REG_W;
  localparam int W     = 19 + 2 * NREG;
  localparam int WAIT_BIT = W - 6;

  localparam logic [3:0] C_MOV = 4'd0,  C_LDI = 4'd1,  C_LDM = 4'd2,  C_STM = 4'd3;
  localparam logic [3:0] C_ADD = 4'd4,  C_SUB = 4'd5,  C_AND = 4'd6,  C_OR  = 4'd7;
  localparam logic [3:0] C_CMP = 4'd8,  C_BRA = 4'd9,  C_BNZ = 4'd10, C_BZ  = 4'd11;
  localparam logic [3:0] C_BM  = 4'd12, C_INC = 4'd13, C_NOT = 4'd14, C_SHL = 4'd15;

  logic clk = 1'b0;
  logic rst_ni, seq_en, flag_zero, flag_neg, mem_ack;
  logic [3:0] opcode;
  logic [REG_W-1:0] dst_idx, src_idx;
  logic pc_to_bus, pc_load, mar_load, mem_rd, mem_wr, mem_wait;
  logic mdr_load_ext, mdr_load_int, mdr_to_bus, ir_load, y_load, z_load;
  logic z_to_bus, add_const4, imm_to_bus, last_step;
  logic [2:0] alu_op;
  logic [NREG-1:0] gpr_load, gpr_to_bus;

  step_ctrl_unit #(.REG_W(REG_W)) u0 (
    .clk(clk), .rst_ni(rst_ni), .seq_en(seq_en), .opcode(opcode),
    .dst_idx(dst_idx), .src_idx(src_idx), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .mem_ack(mem_ack), .pc_to_bus(pc_to_bus), .pc_load(pc_load), .mar_load(mar_load),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wait(mem_wait), .mdr_load_ext(mdr_load_ext),
    .mdr_load_int(mdr_load_int), .mdr_to_bus(mdr_to_bus), .ir_load(ir_load),
    .y_load(y_load), .z_load(z_load), .z_to_bus(z_to_bus), .add_const4(add_const4),
    .imm_to_bus(imm_to_bus), .last_step(last_step), .alu_op(alu_op),
    .gpr_load(gpr_load), .gpr_to_bus(gpr_to_bus)
  );

  always #5 clk = ~clk;

  typedef struct packed { logic [W-1:0] word; logic [7:0] req; } item_t;
  item_t q[$];
  int n_vec = 0, n_bad = 0;
  bit first = 1'b1, finished = 1'b0;

  wire [W-1:0] got = {pc_to_bus, pc_load, mar_load, mem_rd, mem_wr, mem_wait,
                      mdr_load_ext, mdr_load_int, mdr_to_bus, ir_load, y_load, z_load,
                      z_to_bus, add_const4, imm_to_bus, last_step, alu_op, gpr_load, gpr_to_bus};

  function automatic string rname(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic bit br_fails(logic [3:0] o, bit z, bit n);
    return (o == C_BZ && !z) || (o == C_BNZ && z) || (o == C_BM && !n);
  endfunction

  function automatic int ilen(logic [3:0] o, bit z, bit n);
    if (o == C_MOV || o == C_LDI) return 4;
    if (o >= C_BRA && o <= C_BM) return br_fails(o, z, n) ? 4 : 5;
    if (o == C_CMP || o >= C_INC) return 5;
    return 6;
  endfunction

  function automatic int oreq(logic [3:0] o);
    if (o == C_MOV || o == C_LDI) return 9;
    if (o == C_LDM) return 7;
    if (o == C_STM) return 8;
    if (o >= C_ADD && o <= C_OR) return 6;
    if (o == C_CMP) return 10;
    if (o >= C_BRA && o <= C_BM) return 11;
    return 12;
  endfunction

  // expected control word for step st of an instruction, from the requirements
  function automatic logic [W-1:0] expw(int st, logic [3:0] o, int d, int s, bit z, bit n);
    logic pco, pci, mari, rd, wr, wm, mde, mdi, mdo, iri, yi, zi, zo, c4, imo, lst;
    logic [2:0] alu;
    logic [NREG-1:0] ld, dr;
    {pco, pci, mari, rd, wr, wm, mde, mdi, mdo, iri, yi, zi, zo, c4, imo, lst} = '0;
    alu = 3'd0; ld = '0; dr = '0;
    if (st == 1) begin pco = 1; mari = 1; rd = 1; c4 = 1; zi = 1; end
    else if (st == 2) begin zo = 1; pci = 1; yi = 1; wm = 1; mde = 1; end
    else if (st == 3) begin mdo = 1; iri = 1; end
    else if (o == C_MOV) begin dr[s] = 1; ld[d] = 1; lst = 1; end
    else if (o == C_LDI) begin imo = 1; ld[d] = 1; lst = 1; end
    else if (o == C_LDM) begin
      if (st == 4) begin dr[s] = 1; mari = 1; rd = 1; end
      else if (st == 5) begin mde = 1; wm = 1; end
      else begin mdo = 1; ld[d] = 1; lst = 1; end
    end else if (o == C_STM) begin
      if (st == 4) begin dr[d] = 1; mari = 1; end
      else if (st == 5) begin dr[s] = 1; mdi = 1; end
      else begin wr = 1; wm = 1; lst = 1; end
    end else if (o >= C_ADD && o <= C_OR) begin
      if (st == 4) begin dr[d] = 1; yi = 1; end
      else if (st == 5) begin dr[s] = 1; zi = 1; alu = 3'(o - C_ADD); end
      else begin zo = 1; ld[d] = 1; lst = 1; end
    end else if (o == C_CMP) begin
      if (st == 4) begin imo = 1; yi = 1; end
      else begin dr[d] = 1; alu = 3'd1; lst = 1; end
    end else if (o >= C_BRA && o <= C_BM) begin
      if (st == 4) begin imo = 1; zi = 1; lst = br_fails(o, z, n); end
      else begin zo = 1; pci = 1; lst = 1; end
    end else begin
      if (st == 4) begin dr[d] = 1; zi = 1; alu = 3'(o - C_INC + 4'd4); end
      else begin zo = 1; ld[d] = 1; lst = 1; end
    end
    return {pco, pci, mari, rd, wr, wm, mde, mdi, mdo, iri, yi, zi, zo, c4, imo, lst, alu, ld, dr};
  endfunction

  task automatic check(logic [W-1:0] exp, int r);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s control word actual=%h expected=%h", rname(r), got, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected word pushed to the scoreboard
  task automatic cyc(bit r, bit a, logic [3:0] o, int d, int s, bit z, bit n, int st, int req);
    @(posedge clk); #1;
    seq_en = r; mem_ack = a; opcode = o; flag_zero = z; flag_neg = n;
    dst_idx = d[REG_W-1:0]; src_idx = s[REG_W-1:0];
    q.push_back({expw(st, o, d, s, z, n), 8'(req)});
  endtask

  task automatic issue(logic [3:0] o, int d, int s, bit z, bit n,
                       int stall, int frz_at, int frz_n, int tagx);
    int len;
    len = ilen(o, z, n);
    for (int st = 1; st <= len; st++) begin
      int tg;
      logic [W-1:0] e;
      if (st == 1) tg = first ? 1 : 5;
      else if (st <= 3) tg = 2;
      else tg = (tagx != 0) ? tagx : oreq(o);
      if (st == frz_at)
        for (int k = 0; k < frz_n; k++) cyc(1'b0, 1'b1, o, d, s, z, n, st, 4);
      e = expw(st, o, d, s, z, n);
      if (e[WAIT_BIT])
        for (int k = 0; k < stall; k++) cyc(1'b1, 1'b0, o, d, s, z, n, st, 3);
      cyc(1'b1, 1'b1, o, d, s, z, n, st, tg);
    end
    first = 1'b0;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.word, int'(it.req));
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; seq_en = 1'b0; mem_ack = 1'b1; opcode = C_ADD;
    flag_zero = 1'b0; flag_neg = 1'b0; dst_idx = '0; src_idx = '0;
    // R1: T1 word during reset
    repeat (3) @(negedge clk);
    check(expw(1, C_ADD, 0, 0, 0, 0), 1);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expw(1, C_ADD, 0, 0, 0, 0), 1);

    // R1: reset in the middle of an instruction returns to T1 at once
    @(posedge clk); #1 seq_en = 1'b1; dst_idx = 3'd2; src_idx = 3'd5;
    repeat (3) @(posedge clk);
    #1;
    check(expw(4, C_ADD, 2, 5, 0, 0), 6);
    rst_ni = 1'b0; seq_en = 1'b0;
    #1 check(expw(1, C_ADD, 2, 5, 0, 0), 1);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    first = 1'b1;

    issue(C_ADD, 1, 2, 0, 0, 0, 0, 0, 0);
    issue(C_SUB, 7, 0, 0, 0, 0, 0, 0, 13);   // R13: extreme register indices
    issue(C_AND, 3, 3, 1, 1, 0, 0, 0, 0);
    issue(C_OR,  0, 7, 0, 1, 1, 0, 0, 13);
    issue(C_MOV, 5, 6, 0, 0, 0, 0, 0, 0);
    issue(C_LDI, 4, 1, 1, 0, 0, 0, 0, 0);
    issue(C_LDM, 2, 7, 0, 0, 2, 0, 0, 0);    // R3 stalls at T2 and T5
    issue(C_STM, 6, 1, 0, 0, 3, 0, 0, 0);    // R3 stalls at T2 and T6
    issue(C_CMP, 3, 0, 0, 0, 0, 0, 0, 0);
    issue(C_BRA, 0, 0, 1, 1, 0, 0, 0, 0);
    issue(C_BZ,  0, 0, 1, 0, 0, 0, 0, 0);    // R11 taken
    issue(C_BZ,  0, 0, 0, 0, 0, 0, 0, 0);    // R11 fails, ends at T4
    issue(C_BNZ, 0, 0, 0, 1, 0, 0, 0, 0);
    issue(C_BNZ, 0, 0, 1, 1, 0, 0, 0, 0);
    issue(C_BM,  0, 0, 0, 1, 0, 0, 0, 0);
    issue(C_BM,  0, 0, 1, 0, 0, 0, 0, 0);
    issue(C_INC, 0, 3, 0, 0, 0, 0, 0, 0);
    issue(C_NOT, 7, 3, 0, 0, 0, 0, 0, 0);
    issue(C_SHL, 4, 3, 0, 0, 0, 0, 0, 0);
    issue(C_ADD, 6, 2, 0, 0, 1, 4, 3, 0);    // R4 freeze during execute
    issue(C_MOV, 1, 4, 0, 0, 2, 2, 2, 0);    // R4 freeze during fetch, then R3 stall
    cyc(1'b0, 1'b1, C_MOV, 0, 0, 0, 0, 1, 5); // R5 back at T1
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule